// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Register Block

This block sits between the event generators of a real-time clock and the host register bus. It holds three interrupt sources: a periodic tick, an alarm match and an update-ended event. For each source it keeps a sticky flag and an enable bit, and it folds the enabled flags into one summary bit that drives an active-low interrupt line. The block also holds the clock's mode bits: update hold, binary data mode, 24-hour mode, daylight-saving enable and square-wave enable. Neighbouring logic decodes these from the control byte output.

The host reads and writes through a one-cycle bus with a 2-bit register select. Reading the flag register returns its present contents and then wipes every flag, which releases the interrupt line. An event that lands in the same cycle as that read is not lost. The valid-RAM register is read-only and always reports a healthy backup supply. A synchronous active-low reset clears the flags, the three enables and the square-wave enable. It leaves the hold and format bits as they were.

Top module: `rtc_irq_top`

## Requirements
- R1: Each event strobe sets its flag whatever the state of its enable. The flag register (select 1) reports the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3:0 always read 0.
- R2: Bit 7 of the flag register is the summary bit (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable). `irq_n` is low exactly when this bit is 1.
- R3: A read of the flag register returns the value held before the read. From the next cycle all flags read 0 and `irq_n` is high, unless a new event arrives.
- R4: An event that arrives in the same cycle as a flag-register read is recorded and shows on the following read.
- R5: Reset clears all flags and control bits 3:0. Control bits 7:4 keep their values through reset.
- R6: A control write that takes the hold bit (bit 7) from 0 to 1 forces the update enable (bit 2) to 0, whatever value is written to bit 2. A write with hold already 1 stores bit 2 as written.
- R7: Host writes to the flag register (select 1), the valid register (select 2) and the spare select 3 change nothing. Select 3 reads 0x00.
- R8: The valid register (select 2) always reads 0x80, including while reset is asserted.
- R9: The control register (select 0) reads back what was written. Its layout is: bit 0 periodic enable, bit 1 alarm enable, bit 2 update enable, bit 3 square-wave enable, bit 4 binary mode, bit 5 24-hour mode, bit 6 daylight-saving enable, bit 7 hold. The register is also driven on `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 control, 1 flags, 2 valid, 3 spare |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a read of select 1 clears the flags |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| ev_periodic | input | 1 | Periodic tick event strobe |
| ev_alarm | input | 1 | Alarm match event strobe |
| ev_update | input | 1 | Update-ended event strobe |
| irq_n | output | 1 | Active-low interrupt request |
| ctrl_o | output | 8 | Control register contents for neighbouring logic |

## Verification
The embedded properties run on every cycle. They check that each event strobe leaves its flag set, and that a flag read leaves exactly the same-cycle events behind. They also check that a hold rise clears the update enable, that a low `irq_n` always has a flag behind it, and that writes to the read-only selects leave the flags alone. Several behaviours are shown only by the bench scenarios:
- which bit position each source occupies;
- that format bits survive reset while enables do not;
- that enabling a source after its flag was set raises the interrupt;
- the fixed valid-register value during reset.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, register selects and bit positions for the RTC
// interrupt flag block. Assumes an 8-bit register bus with a 2-bit select.
package rtc_irq_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 3;   // periodic, alarm, update

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_VALID = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_t;

    // Source indices; also the control-byte enable positions.
    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_UPD = 2;

    // Control byte layout.
    localparam int C_SQW  = 3;
    localparam int C_BIN  = 4;
    localparam int C_H24  = 5;
    localparam int C_DST  = 6;
    localparam int C_HOLD = 7;
    localparam int N_RST_BITS = 4;   // bits below this index are cleared by reset

    // Flag byte layout.
    localparam int F_SUM = 7;
    localparam int F_TOP = 6;        // source i sits at F_TOP - i

    localparam logic [DATA_W-1:0] VALID_VALUE = 8'h80;
endpackage

// File: rtl/rtc_irq_ctrl.sv
// Control register: holds the enables, the square-wave enable and the
// mode/hold bits. Assumes a one-cycle write strobe. The low bits are cleared
// by the synchronous reset; the upper bits are never reset. A rise of the
// hold bit caused by a write forces the update enable low.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o
);
    logic [N_RST_BITS-1:0]        low_q;
    logic [DATA_W-1:N_RST_BITS]   high_q;
    logic [N_RST_BITS-1:0]        low_d;
    logic                         hold_rise;

    // Detect a write that takes hold from 0 to 1.
    assign hold_rise = wr_i && wdata_i[C_HOLD] && !high_q[C_HOLD];

    // Next value of the resettable bits, with the hold side effect applied.
    always_comb begin
        low_d = wdata_i[N_RST_BITS-1:0];
        if (hold_rise) low_d[SRC_UPD] = 1'b0;
    end

    // Resettable enables and square-wave enable.
    always_ff @(posedge clk) begin
        if (!rst_n)    low_q <= '0;
        else if (wr_i) low_q <= low_d;
    end

    // Mode and hold bits: no reset, write only.
    always_ff @(posedge clk) begin
        if (wr_i) high_q <= wdata_i[DATA_W-1:N_RST_BITS];
    end

    assign ctrl_o = {high_q, low_q};

    // R6
    hold_clears_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[C_HOLD] && !ctrl_o[C_HOLD]) |=> !ctrl_o[SRC_UPD]);
endmodule

// File: rtl/rtc_irq_flags.sv
// Sticky event flags, one per source (generate). A flag is set by its strobe
// whatever its enable. A clear request wipes all flags, but strobes arriving
// in the same cycle win over the clear. Assumes strobes are already
// synchronous to clk.
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int NSRC = N_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [NSRC-1:0] ev_i,
    output logic [NSRC-1:0] flag_o
);
    logic [NSRC-1:0] flag_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // One sticky flag: reset, else set by its strobe, else cleared by a read.
        always_ff @(posedge clk) begin
            if (!rst_n)       flag_q[i] <= 1'b0;
            else if (ev_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i)   flag_q[i] <= 1'b0;
        end

        // R1
        ev_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> flag_o[i]);
    end

    assign flag_o = flag_q;

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flag_o == $past(ev_i)));
endmodule

// File: rtl/rtc_irq_rdmux.sv
// Read-data selector: chooses among control, flag, valid and spare bytes.
// Purely combinational; assumes the select is stable during a read.
module rtc_irq_rdmux
    import rtc_irq_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] ctrl_i,
    input  logic [DATA_W-1:0] flag_i,
    output logic [DATA_W-1:0] data_o
);
    // Select the addressed byte.
    always_comb begin
        unique case (reg_sel_t'(sel_i))
            SEL_CTRL:  data_o = ctrl_i;
            SEL_FLAG:  data_o = flag_i;
            SEL_VALID: data_o = VALID_VALUE;
            default:   data_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_irq_top.sv
// RTC interrupt flag block top: decodes the register bus, holds control and
// flags, forms the summary bit and the active-low interrupt. Assumes
// single-cycle read and write strobes and synchronous event strobes.
module rtc_irq_top
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    output logic              irq_n,
    output logic [DATA_W-1:0] ctrl_o
);
    logic              wr_ctrl;
    logic              rd_flag;
    logic              wr_ro;
    logic [N_SRC-1:0]  ev_vec;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  enables;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] flag_byte;
    logic              summary;

    // Bus decode.
    assign wr_ctrl = bus_wr && (reg_sel_t'(bus_sel) == SEL_CTRL);
    assign wr_ro   = bus_wr && (reg_sel_t'(bus_sel) != SEL_CTRL);
    assign rd_flag = bus_rd && (reg_sel_t'(bus_sel) == SEL_FLAG);

    assign ev_vec = {ev_update, ev_alarm, ev_periodic};

    rtc_irq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (bus_wdata),
        .ctrl_o  (ctrl)
    );

    rtc_irq_flags #(.NSRC(N_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (rd_flag),
        .ev_i   (ev_vec),
        .flag_o (flags)
    );

    assign enables = ctrl[N_SRC-1:0];
    assign summary = |(flags & enables);

    // Build the flag byte: summary on top, sources below, low bits zero.
    always_comb begin
        flag_byte        = '0;
        flag_byte[F_SUM] = summary;
        for (int i = 0; i < N_SRC; i++) flag_byte[F_TOP-i] = flags[i];
    end

    rtc_irq_rdmux u_rdmux (
        .sel_i  (bus_sel),
        .ctrl_i (ctrl),
        .flag_i (flag_byte),
        .data_o (bus_rdata)
    );

    assign irq_n  = ~summary;
    assign ctrl_o = ctrl;

    // R2
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flags != '0));

    // R7
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ro && !rd_flag && ev_vec == '0) |=> $stable(flags));
endmodule

// File: tb/sim_rtc_irq_top.sv
// Scoreboard bench: driver tasks push expected read results into a queue;
// a monitor pops and compares when the design presents a read.
module sim_rtc_irq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic       irq_n;
    logic [7:0] ctrl_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] data;
        logic       irqn;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rtc_irq_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .irq_n(irq_n), .ctrl_o(ctrl_o)
    );

    // Monitor: 1 ns after each falling edge, compare a presented read.
    always @(negedge clk) begin
        #1;
        if (bus_rd) begin
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bus_rdata !== e.data || irq_n !== e.irqn) begin
                    failures++;
                    $display("FAIL %s: data=%h irq_n=%b expected data=%h irq_n=%b",
                             e.tag, bus_rdata, irq_n, e.data, e.irqn);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        ev_periodic = 0; ev_alarm = 0; ev_update = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1;
        idle();
    endtask

    // Read, optionally with events in the same cycle.
    task automatic rd_ev(input logic [1:0] s, input logic [7:0] d, input logic irqn,
                         input logic [2:0] ev, input string tag);
        exp_t e;
        @(negedge clk);
        e.tag = tag; e.data = d; e.irqn = irqn;
        sb.push_back(e);
        bus_sel = s; bus_rd = 1;
        {ev_update, ev_alarm, ev_periodic} = ev;
        idle();
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] d, input logic irqn,
                      input string tag);
        rd_ev(s, d, irqn, 3'b000, tag);
    endtask

    task automatic fire(input logic [2:0] ev);
        @(negedge clk);
        {ev_update, ev_alarm, ev_periodic} = ev;
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd(2'd2, 8'h80, 1'b1, "R8 valid during reset");
        rst_n = 1;
        rd(2'd1, 8'h00, 1'b1, "R5 flags after reset");
        // Control read/write.
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h7F);
        rd(2'd0, 8'h7F, 1'b1, "R9 control readback");
        // Reset keeps upper bits, clears lower bits and flags.
        fire(3'b111);
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        rd(2'd0, 8'h70, 1'b1, "R5 control after reset");
        rd(2'd1, 8'h00, 1'b1, "R5 flags cleared by reset");
        wr(2'd0, 8'h00);
        // Flags set with enables off.
        fire(3'b001);
        rd(2'd1, 8'h40, 1'b1, "R1 periodic flag, enable off");
        rd(2'd1, 8'h00, 1'b1, "R3 flags cleared after read");
        fire(3'b110);
        rd(2'd1, 8'h30, 1'b1, "R1 alarm and update flags");
        // Enabled sources drive the interrupt.
        wr(2'd0, 8'h01);
        fire(3'b001);
        rd(2'd0, 8'h01, 1'b0, "R2 periodic irq, control read keeps flags");
        rd(2'd1, 8'hC0, 1'b0, "R2 periodic summary bit");
        rd(2'd0, 8'h01, 1'b1, "R3 irq released after flag read");
        wr(2'd0, 8'h02);
        fire(3'b010);
        rd(2'd1, 8'hA0, 1'b0, "R2 alarm summary");
        wr(2'd0, 8'h04);
        fire(3'b100);
        rd(2'd1, 8'h90, 1'b0, "R2 update summary");
        wr(2'd0, 8'h02);
        fire(3'b100);
        rd(2'd1, 8'h10, 1'b1, "R2 mismatched enable gives no irq");
        // Flag set first, enable later.
        wr(2'd0, 8'h00);
        fire(3'b010);
        wr(2'd0, 8'h02);
        rd(2'd0, 8'h02, 1'b0, "R2 late enable raises irq");
        rd(2'd1, 8'hA0, 1'b0, "R2 late enable summary");
        // Event during flag read.
        wr(2'd0, 8'h00);
        rd_ev(2'd1, 8'h00, 1'b1, 3'b100, "R4 read returns pre-event value");
        rd(2'd1, 8'h10, 1'b1, "R4 same-cycle event kept");
        // Hold side effect.
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h84);
        rd(2'd0, 8'h80, 1'b1, "R6 hold rise clears update enable");
        wr(2'd0, 8'h84);
        rd(2'd0, 8'h84, 1'b1, "R6 hold already set keeps update enable");
        wr(2'd0, 8'h04);
        rd(2'd0, 8'h04, 1'b1, "R6 hold clear keeps update enable");
        // Read-only writes ignored.
        wr(2'd0, 8'h00);
        fire(3'b001);
        wr(2'd1, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, 8'h40, 1'b1, "R7 flag write ignored");
        wr(2'd2, 8'h00);
        rd(2'd2, 8'h80, 1'b1, "R8 valid after write");
        wr(2'd3, 8'h5A);
        rd(2'd3, 8'h00, 1'b1, "R7 spare reads zero");
        rd(2'd0, 8'h00, 1'b1, "R7 control untouched by other writes");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: %0d items never observed", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule